// File: doc/BRIEF.md
# Position-Based Replay Dependence Tracker

This block sits beside an issue queue that schedules loads speculatively. Loads are issued on the assumption that they hit. For each queue entry it records which in-flight loads the entry's operands depend on. Each dependence is kept as a bit in a small grid. The grid has one column per memory issue slot and one row per pipeline stage between schedule and verify. When an instruction issues, its grid is moved down one row and sent out alongside its wakeup tag. Every consumer that was waiting on that tag ORs the grid into the copy held for that source operand. All grids then move down one row on each clock edge, in step with the instructions in the pipeline.

A load that issues on memory slot k plants a bit in column k of the top row. That bit therefore reaches the bottom row in the same cycle the load reaches verify. The verify stage drives one kill line per memory port. Any entry whose bottom row has a bit set in a killed column is reported as invalidated for one cycle. The same holds for any entry whose source operand carries such a bit. Such an entry loses readiness only on the operand that carried the bad dependence, so it waits to be woken again. A missing load clears its own issued state, so it becomes eligible to replay. Entries with no path to the missing load are left untouched.

The environment allocates entries, names the entry to issue each cycle, and drives the kill lines. The block returns per-entry ready and invalidate flags.

Top module: `rmt_tracker`

## Requirements
- R1: During and straight after a synchronous active-high reset, every ready flag and every invalidate flag is 0.
- R2: After an allocation, the entry's ready flag is 1 when neither source is marked as waiting. It is 0 while any waiting source has not been woken.
- R3: Issuing entry P clears P's ready flag after that edge. The same edge wakes every source of any allocated entry whose stored tag equals P.
- R4: A load issued on memory slot k at edge E0 is invalidated when kill line k is high at edge E0+6. So is every entry that depends on it, directly or through a chain of issued producers. The invalidate flag is 1 for exactly the one cycle after that edge.
- R5: When a kill occurs, entries with no dependence path to the killed load are not invalidated. Entries whose only dependences are on loads in a different memory slot are not invalidated either.
- R6: A dependence bit is discarded after it leaves the bottom row. A kill line raised at any edge later than E0+6 does not invalidate the load or its dependents.
- R7: An invalidated entry clears the ready state of each source that carried the killed dependence, so its ready flag drops. Sources with no such dependence stay ready. An invalidated load that was itself issued returns to ready so it can replay.
- R8: If an entry is issued at the same edge at which it is invalidated, its wakeup broadcast is cancelled and its consumers stay not ready.
- R9: A load re-issued after invalidation wakes its consumers again and starts a fresh six-stage window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Write a new instruction into entry alloc_idx |
| alloc_idx | input | 4 | Entry being allocated |
| alloc_tag_a | input | 4 | Producer entry of source A |
| alloc_wait_a | input | 1 | Source A still waits for its producer |
| alloc_tag_b | input | 4 | Producer entry of source B |
| alloc_wait_b | input | 1 | Source B still waits for its producer |
| iss_en | input | 1 | An entry issues this cycle |
| iss_idx | input | 4 | Entry that issues; also its wakeup tag |
| iss_load | input | 1 | The issuing entry is a load |
| iss_slot | input | 1 | Memory slot used by the issuing load |
| kill | input | 2 | Per-port miss indication from verify |
| o_ready | output | 16 | Entry allocated, all sources ready, not issued |
| o_inval | output | 16 | Entry invalidated at the previous edge |

## Verification
The checker assumes the environment issues only an entry whose ready flag is 1, at most one per cycle. It also assumes the environment never allocates and issues the same entry in one cycle. The bench keeps to these rules because each task first reads back the ready flags and only then issues an entry known to be ready. Kill lines are raised only at the edge that matches the verify timing of a chosen load, except where a scenario tests a wrong slot or a late edge on purpose. For that reason every invalidate pulse the checker sees can be traced to a kill on the previous edge.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  // Default geometry: memory issue slots, schedule-to-verify stages, queue entries
  localparam int unsigned DEF_SLOTS   = 2;
  localparam int unsigned DEF_DEPTH   = 6;
  localparam int unsigned DEF_ENTRIES = 16;
  // Number of source operands per entry
  localparam int unsigned NUM_SRC     = 2;
endpackage

// File: rtl/rmt_rowshift.sv
// Moves a dependence grid down one stage and tests its bottom row against kill lines.
module rmt_rowshift #(
  parameter int unsigned SLOTS = rmt_pkg::DEF_SLOTS,
  parameter int unsigned DEPTH = rmt_pkg::DEF_DEPTH,
  localparam int unsigned MW   = SLOTS * DEPTH
) (
  input  logic [MW-1:0]    mat,
  input  logic [SLOTS-1:0] kill,
  output logic [MW-1:0]    nxt,
  output logic             hit
);
  localparam int unsigned LAST = (DEPTH - 1) * SLOTS;

  // Row r occupies bits [r*SLOTS +: SLOTS]; row 0 is the schedule stage
  assign hit = |(mat[LAST +: SLOTS] & kill);
  assign nxt = {mat[LAST-1:0], {SLOTS{1'b0}}};
endmodule

// File: rtl/rmt_entry.sv
// One issue-queue entry: source readiness plus per-source and own dependence grids.
module rmt_entry #(
  parameter int unsigned SLOTS = rmt_pkg::DEF_SLOTS,
  parameter int unsigned DEPTH = rmt_pkg::DEF_DEPTH,
  parameter int unsigned IW    = 4,
  localparam int unsigned MW   = SLOTS * DEPTH,
  localparam int unsigned NS   = rmt_pkg::NUM_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_hit,
  input  logic [IW-1:0]    alloc_tag_a,
  input  logic             alloc_wait_a,
  input  logic [IW-1:0]    alloc_tag_b,
  input  logic             alloc_wait_b,
  input  logic             bc_valid,
  input  logic [IW-1:0]    bc_idx,
  input  logic [MW-1:0]    bc_mat,
  input  logic             self_iss,
  input  logic [MW-1:0]    load_bits,
  input  logic [SLOTS-1:0] kill,
  output logic [MW-1:0]    full_sh,
  output logic             kill_now,
  output logic             ready,
  output logic             inval_q
);
  logic                   valid_q;
  logic                   issued_q;
  logic [NS-1:0]          rdy_q;
  logic [NS-1:0][IW-1:0]  tag_q;
  logic [NS-1:0][MW-1:0]  src_q;
  logic [MW-1:0]          self_q;

  // Index NS holds the entry's own grid, 0..NS-1 the source grids
  logic [NS:0][MW-1:0]    cur;
  logic [NS:0][MW-1:0]    sh;
  logic [NS:0]            hit;
  logic [NS-1:0]          wake;

  assign cur = {self_q, src_q};

  for (genvar k = 0; k <= NS; k++) begin : g_grid
    rmt_rowshift #(.SLOTS(SLOTS), .DEPTH(DEPTH)) u_shift (
      .mat  (cur[k]),
      .kill (kill),
      .nxt  (sh[k]),
      .hit  (hit[k])
    );
  end

  for (genvar s = 0; s < NS; s++) begin : g_wake
    assign wake[s] = valid_q & ~rdy_q[s] & bc_valid & (tag_q[s] == bc_idx);
  end

  always_comb begin
    full_sh = sh[NS];
    for (int s = 0; s < NS; s++) full_sh = full_sh | sh[s];
  end

  assign kill_now = valid_q & (|hit);
  assign ready    = valid_q & (&rdy_q) & ~issued_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      issued_q <= 1'b0;
      rdy_q    <= '0;
      tag_q    <= '0;
      src_q    <= '0;
      self_q   <= '0;
      inval_q  <= 1'b0;
    end else if (alloc_hit) begin
      valid_q  <= 1'b1;
      issued_q <= 1'b0;
      rdy_q    <= {~alloc_wait_b, ~alloc_wait_a};
      tag_q    <= {alloc_tag_b, alloc_tag_a};
      src_q    <= '0;
      self_q   <= '0;
      inval_q  <= 1'b0;
    end else begin
      inval_q  <= kill_now;
      issued_q <= kill_now ? 1'b0 : (issued_q | self_iss);
      if (kill_now)      self_q <= '0;
      else if (self_iss) self_q <= sh[NS] | load_bits;
      else               self_q <= sh[NS];
      for (int s = 0; s < NS; s++) begin
        if (hit[s]) begin
          rdy_q[s] <= 1'b0;
          src_q[s] <= '0;
        end else if (wake[s]) begin
          rdy_q[s] <= 1'b1;
          src_q[s] <= bc_mat;
        end else begin
          src_q[s] <= sh[s];
        end
      end
    end
  end
endmodule

// File: rtl/rmt_tracker.sv
// Top: entry array, wakeup broadcast with dependence grid, kill-driven invalidation.
module rmt_tracker #(
  parameter int unsigned SLOTS   = rmt_pkg::DEF_SLOTS,
  parameter int unsigned DEPTH   = rmt_pkg::DEF_DEPTH,
  parameter int unsigned ENTRIES = rmt_pkg::DEF_ENTRIES,
  localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_en,
  input  logic [IW-1:0]      alloc_idx,
  input  logic [IW-1:0]      alloc_tag_a,
  input  logic               alloc_wait_a,
  input  logic [IW-1:0]      alloc_tag_b,
  input  logic               alloc_wait_b,
  input  logic               iss_en,
  input  logic [IW-1:0]      iss_idx,
  input  logic               iss_load,
  input  logic [SW-1:0]      iss_slot,
  input  logic [SLOTS-1:0]   kill,
  output logic [ENTRIES-1:0] o_ready,
  output logic [ENTRIES-1:0] o_inval
);
  localparam int unsigned MW = SLOTS * DEPTH;

  logic [ENTRIES-1:0][MW-1:0] shv;
  logic [ENTRIES-1:0]         kill_now;
  logic [MW-1:0]              load_bits;
  logic [MW-1:0]              bc_mat;
  logic                       bc_valid;

  // A load plants its own bit in the top row, column = memory slot
  for (genvar s = 0; s < SLOTS; s++) begin : g_plant
    assign load_bits[s] = iss_load && (iss_slot == SW'(s));
  end
  assign load_bits[MW-1:SLOTS] = '0;

  // An issuer invalidated at this edge must not wake anybody
  assign bc_valid = iss_en & ~kill_now[iss_idx];
  assign bc_mat   = shv[iss_idx] | load_bits;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    rmt_entry #(.SLOTS(SLOTS), .DEPTH(DEPTH), .IW(IW)) u_ent (
      .clk          (clk),
      .rst          (rst),
      .alloc_hit    (alloc_en && (alloc_idx == IW'(e))),
      .alloc_tag_a  (alloc_tag_a),
      .alloc_wait_a (alloc_wait_a),
      .alloc_tag_b  (alloc_tag_b),
      .alloc_wait_b (alloc_wait_b),
      .bc_valid     (bc_valid),
      .bc_idx       (iss_idx),
      .bc_mat       (bc_mat),
      .self_iss     (bc_valid && (iss_idx == IW'(e))),
      .load_bits    (load_bits),
      .kill         (kill),
      .full_sh      (shv[e]),
      .kill_now     (kill_now[e]),
      .ready        (o_ready[e]),
      .inval_q      (o_inval[e])
    );
  end
endmodule

// File: rtl/rmt_checker.sv
module rmt_checker #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned SLOTS   = 2,
  parameter int unsigned IW      = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               alloc_en,
  input logic [IW-1:0]      alloc_idx,
  input logic               iss_en,
  input logic [IW-1:0]      iss_idx,
  input logic [SLOTS-1:0]   kill,
  input logic [ENTRIES-1:0] o_ready,
  input logic [ENTRIES-1:0] o_inval
);
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (o_ready == '0 && o_inval == '0)); // R1

  AST_INVAL_NEEDS_KILL: assert property (@(posedge clk) disable iff (rst) (|o_inval) |-> $past(|kill)); // R4

  AST_ISSUE_ONLY_READY: assert property (@(posedge clk) disable iff (rst) iss_en |-> o_ready[iss_idx]); // R3

  AST_ISSUED_LEAVES_READY: assert property (@(posedge clk) disable iff (rst) (iss_en && !(alloc_en && alloc_idx == iss_idx)) |=> !o_ready[$past(iss_idx)]); // R3

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cause
    AST_READY_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(o_ready[i]) |-> ($past(alloc_en && alloc_idx == IW'(i)) || $past(iss_en) || $past(|kill))); // R2
  end
endmodule

bind rmt_tracker rmt_checker #(.ENTRIES(ENTRIES), .SLOTS(SLOTS), .IW(IW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .alloc_en  (alloc_en),
  .alloc_idx (alloc_idx),
  .iss_en    (iss_en),
  .iss_idx   (iss_idx),
  .kill      (kill),
  .o_ready   (o_ready),
  .o_inval   (o_inval)
);

// File: tb/test_rmt_tracker.sv
module test_rmt_tracker;
  logic        clk = 1'b0;
  logic        rst;
  logic        alloc_en;
  logic [3:0]  alloc_idx;
  logic [3:0]  alloc_tag_a;
  logic        alloc_wait_a;
  logic [3:0]  alloc_tag_b;
  logic        alloc_wait_b;
  logic        iss_en;
  logic [3:0]  iss_idx;
  logic        iss_load;
  logic [0:0]  iss_slot;
  logic [1:0]  kill;
  logic [15:0] o_ready;
  logic [15:0] o_inval;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rmt_tracker i_rmt_tracker (
    .clk(clk), .rst(rst),
    .alloc_en(alloc_en), .alloc_idx(alloc_idx),
    .alloc_tag_a(alloc_tag_a), .alloc_wait_a(alloc_wait_a),
    .alloc_tag_b(alloc_tag_b), .alloc_wait_b(alloc_wait_b),
    .iss_en(iss_en), .iss_idx(iss_idx), .iss_load(iss_load), .iss_slot(iss_slot),
    .kill(kill), .o_ready(o_ready), .o_inval(o_inval)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_en = 1'b0; alloc_idx = '0; alloc_tag_a = '0; alloc_wait_a = 1'b0;
    alloc_tag_b = '0; alloc_wait_b = 1'b0;
    iss_en = 1'b0; iss_idx = '0; iss_load = 1'b0; iss_slot = '0; kill = '0;
  endtask

  // Advance one edge; outputs are sampled 1 ns after it
  task automatic tick();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic do_alloc(input int idx, input int ta, input bit wa, input int tb, input bit wb);
    alloc_en = 1'b1; alloc_idx = 4'(idx);
    alloc_tag_a = 4'(ta); alloc_wait_a = wa;
    alloc_tag_b = 4'(tb); alloc_wait_b = wb;
    tick();
  endtask

  task automatic do_issue(input int idx, input bit ld, input int slot);
    iss_en = 1'b1; iss_idx = 4'(idx); iss_load = ld; iss_slot = 1'(slot);
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle_inputs();
    repeat (3) tick();
    rst = 1'b0;
    chk("R1 ready after reset", o_ready, 16'h0000);
    chk("R1 inval after reset", o_inval, 16'h0000);
  endtask

  // Load 0 on slot 1 with chain 0->1->2, independent 3->4, and 5 fed by 0 and 3
  task automatic t_chain();
    do_alloc(0, 0, 0, 0, 0);
    do_alloc(1, 0, 1, 0, 0);
    do_alloc(2, 1, 1, 0, 0);
    do_alloc(3, 0, 0, 0, 0);
    do_alloc(4, 3, 1, 0, 0);
    do_alloc(5, 0, 1, 3, 1);
    chk("R2 ready after allocation", o_ready, 16'h0009);
    do_issue(0, 1, 1);                               // E0
    chk("R3 load issue wakes 1 and 5a", o_ready, 16'h000A);
    do_issue(1, 0, 0);                               // E1
    chk("R3 chain wake of 2", o_ready, 16'h000C);
    do_issue(3, 0, 0);                               // E2
    chk("R3 independent wake of 4 and 5b", o_ready, 16'h0034);
    do_issue(2, 0, 0);                               // E3
    chk("R3 issue of 2", o_ready, 16'h0030);
    do_issue(5, 0, 0);                               // E4
    chk("R3 issue of 5", o_ready, 16'h0010);
    tick();                                          // E5
    kill = 2'b10;
    tick();                                          // E6: verify of load 0
    chk("R4 R5 transitive invalidation", o_inval, 16'h0027);
    chk("R7 ready after invalidation", o_ready, 16'h0011);
    tick();                                          // E7
    chk("R4 invalidate is a one-cycle pulse", o_inval, 16'h0000);
    // Replay of the load
    do_issue(0, 1, 1);                               // G0
    chk("R9 replayed load wakes consumers", o_ready, 16'h0032);
    repeat (6) tick();                               // G1..G6, no kill
    chk("R9 no invalidation without kill", o_inval, 16'h0000);
    kill = 2'b10;
    tick();                                          // G7, one edge late
    chk("R6 late kill inval", o_inval, 16'h0000);
    chk("R6 late kill ready", o_ready, 16'h0032);
  endtask

  // Load 6 on slot 0, consumer 7; slot 1 killed at its verify edge
  task automatic t_slot();
    do_alloc(6, 0, 0, 0, 0);
    do_alloc(7, 6, 1, 0, 0);
    chk("R2 waiting source blocks ready", o_ready, 16'h0072);
    do_issue(6, 1, 0);                               // H0
    chk("R3 wake of 7", o_ready, 16'h00B2);
    repeat (5) tick();
    kill = 2'b10;
    tick();                                          // H6, wrong slot
    chk("R5 other slot not invalidated", o_inval, 16'h0000);
    chk("R5 other slot ready unchanged", o_ready, 16'h00B2);
  endtask

  // Load 8 on slot 0; 9 issues exactly at the kill edge, so 10 must not wake
  task automatic t_suppress();
    do_alloc(8, 0, 0, 0, 0);
    do_alloc(9, 8, 1, 0, 0);
    do_alloc(10, 9, 1, 0, 0);
    do_alloc(11, 8, 1, 0, 0);
    do_issue(8, 1, 0);                               // J0
    chk("R3 wake of 9 and 11", o_ready, 16'h0AB2);
    repeat (5) tick();
    kill = 2'b01;
    iss_en = 1'b1; iss_idx = 4'd9; iss_load = 1'b0;
    tick();                                          // J6
    chk("R4 R8 invalidation with simultaneous issue", o_inval, 16'h0B00);
    chk("R8 R7 cancelled wakeup and replay state", o_ready, 16'h01B2);
  endtask

  initial begin
    rst = 1'b1;
    idle_inputs();
    t_reset();
    t_chain();
    t_slot();
    t_suppress();
    repeat (2) tick();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule